// File: doc/BRIEF.md
# Margin-Mode EPROM Programming Sequencer

This block drives the pins of a UV-erasable byte-wide EPROM through the quick programming method, which depends on the part's internal margin mode. When `start` is pulsed, it raises the identifier line to high voltage. It then applies programming voltage and latches margin mode by holding the margin-select line high around a chip-enable rising edge. Next it walks the address space. Every byte gets fixed-width program pulses, and a verify read follows each pulse. A byte is finished as soon as it reads back equal to the memory image. No longer overprogram pulse is ever applied.

When the last byte is finished, or when a byte has used up its pulse allowance, the sequencer tears down in the reverse order of setup. It clears margin mode with the select line low, removes programming voltage, and finally releases the identifier line. A run that programmed every byte then reads the whole array back at normal supply with no high voltage applied. The first byte that differs in that read-back is reported.

The memory image is read through a combinational port that is addressed by the sequencer. Every pin delay is a parameter counted in clock cycles. All pin levels are decoded from the state register, so each phase lasts exactly its parameter.

Top module: `margin_prog_seq`

## Requirements
- R1: Outside a run (`busy` low, including after reset), chip enable and output enable are high, and programming voltage, high voltage on the identifier line, the raised-supply request and the data drive are all off.
- R2: A run raises `ep_a9_hv` first. `ep_vpp_en` rises T_A9_VPP cycles later. Every chip-enable fall while `ep_vpp_en` is high comes at least T_VPP_CE cycles after programming voltage last rose, and programming voltage is never on without the identifier high voltage.
- R3: Margin mode is latched by a chip-enable rise while programming voltage is on and data is not driven. `ep_margin_line` is high for at least T_A10_SU cycles before that rise and stays unchanged for at least T_A10_HOLD cycles after it. Every program pulse occurs with margin mode set.
- R4: Each program pulse holds chip enable low for exactly T_PULSE cycles, with programming voltage on, output enable high and `ep_dq_out` equal to the image byte at `ep_addr`. Each pulse is followed by a verify read: programming voltage off, chip enable and output enable low, for T_VERIFY cycles, compared on the last cycle.
- R5: A byte that verifies equal to the image moves the sequencer to the next address with its pulse count restarted at 0. Each address receives exactly the number of pulses it needs, at least one.
- R6: If a byte still mismatches after MAX_PULSES (default 25) pulses, `fail` is set and `fail_addr` takes that address. No further pulses are applied to any address, and no read-back pass is run.
- R7: Teardown clears margin mode by a chip-enable rise with `ep_margin_line` low. Programming voltage is then removed, and `ep_a9_hv` falls at least T_A9_HOLD cycles after that.
- R8: After a run with no program failure, every address is read for T_VERIFY cycles with programming voltage, identifier high voltage and `ep_vcc_hi` off. The first mismatching address sets `fail` and `fail_addr`, and the read-back stops there.
- R9: `done` rises when the run ends and stays high, together with `fail`, until the next accepted `start`. `busy` is high throughout a run, and `start` has no effect while `busy` is high.
- R10: Programming voltage falls only after chip enable has been high for at least T_VPP_HOLD cycles since its last rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (sticky until next start) |
| fail | output | 1 | Run failed (sticky until next start) |
| fail_addr | output | AW | Address of the failing byte |
| img_addr | output | AW | Memory image read address |
| img_data | input | DW | Memory image byte at img_addr |
| ep_addr | output | AW | EPROM address lines |
| ep_dq_out | output | DW | Data driven to the EPROM during programming |
| ep_dq_oe | output | 1 | Data drive enable |
| ep_dq_in | input | DW | Data read from the EPROM |
| ep_ce_n | output | 1 | Chip enable, active low |
| ep_oe_n | output | 1 | Output enable, active low (while programming voltage is off) |
| ep_vpp_en | output | 1 | Apply programming voltage on the shared enable/supply pin |
| ep_a9_hv | output | 1 | Apply high voltage on the identifier address line |
| ep_margin_line | output | 1 | Level for the margin-select address line |
| ep_vcc_hi | output | 1 | Request raised supply for programming |

## Verification
Some rules hold on every cycle and are checked by the in-line assertions. These are the pin-ordering rules: programming voltage only with identifier high voltage, data driven into a low chip enable only with programming voltage on, programming voltage falling only after a chip-enable high, the identifier line released only after programming voltage is gone, and a quiet bus when idle. The assertions also cover the counter limits that keep pulses within the allowance. Other behaviour depends on the contents of the array and shows only in the bench's scenarios. This covers the number of pulses each byte receives, the margin state seen by every pulse, the exact cycle distances between pin edges, the stop at the pulse limit, and the read-back catching a byte that changed after programming. The bench models those with an array that needs a chosen number of pulses per byte.

// File: rtl/mm_seq_pkg.sv
package mm_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_A9, ST_VPP, ST_MSET_LO, ST_MSET_HI, ST_PRE, ST_PULSE,
    ST_PHOLD, ST_VERIFY, ST_TD_PRE, ST_MRST_LO, ST_MRST_HI, ST_VPP_OFF,
    ST_CMP, ST_END
  } mm_state_e;

  function automatic int unsigned cyc_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles spent in each phase; every timing argument must be at least 1.
  function automatic int unsigned phase_len(
      mm_state_e s, int unsigned a9_to_vpp, int unsigned vpp_to_ce,
      int unsigned sel_setup, int unsigned sel_hold, int unsigned vpp_hold,
      int unsigned a9_hold, int unsigned pulse, int unsigned vfy);
    case (s)
      ST_A9:                        return a9_to_vpp;
      ST_VPP, ST_PRE, ST_TD_PRE:    return vpp_to_ce;
      ST_MSET_LO, ST_MRST_LO:       return sel_setup;
      ST_MSET_HI:                   return sel_hold;
      ST_PULSE:                     return pulse;
      ST_PHOLD:                     return vpp_hold;
      ST_MRST_HI:                   return cyc_max(sel_hold, vpp_hold);
      ST_VPP_OFF:                   return a9_hold;
      ST_VERIFY, ST_CMP:            return vfy;
      default:                      return 1;
    endcase
  endfunction

endpackage

// File: rtl/mm_phase_timer.sv
module mm_phase_timer #(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == TW'($past(cnt) - 1'b1))); // R4
endmodule

// File: rtl/mm_pulse_ctr.sv
module mm_pulse_ctr #(
  parameter int unsigned MAX_PULSES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic exhausted
);
  localparam int unsigned PW = $clog2(MAX_PULSES + 1);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (inc)    cnt <= cnt + 1'b1;
  end

  assign exhausted = (cnt == PW'(MAX_PULSES));

  AST_PULSE_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !exhausted); // R6
endmodule

// File: rtl/mm_addr_ctr.sv
module mm_addr_ctr #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr <= '0;
    else if (clr)    addr <= '0;
    else if (inc)    addr <= addr + 1'b1;
  end

  assign last = &addr;

  AST_ADDR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !last); // R5
endmodule

// File: rtl/margin_prog_seq.sv
module margin_prog_seq
  import mm_seq_pkg::*;
#(
  parameter int unsigned AW         = 6,
  parameter int unsigned DW         = 8,
  parameter int unsigned T_A9_VPP   = 3,
  parameter int unsigned T_VPP_CE   = 3,
  parameter int unsigned T_A10_SU   = 2,
  parameter int unsigned T_A10_HOLD = 2,
  parameter int unsigned T_VPP_HOLD = 3,
  parameter int unsigned T_A9_HOLD  = 3,
  parameter int unsigned T_PULSE    = 6,
  parameter int unsigned T_VERIFY   = 2,
  parameter int unsigned MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [AW-1:0] img_addr,
  input  logic [DW-1:0] img_data,
  output logic [AW-1:0] ep_addr,
  output logic [DW-1:0] ep_dq_out,
  output logic          ep_dq_oe,
  input  logic [DW-1:0] ep_dq_in,
  output logic          ep_ce_n,
  output logic          ep_oe_n,
  output logic          ep_vpp_en,
  output logic          ep_a9_hv,
  output logic          ep_margin_line,
  output logic          ep_vcc_hi
);
  localparam int unsigned LMAX = cyc_max(cyc_max(cyc_max(T_A9_VPP, T_VPP_CE),
                                 cyc_max(T_A10_SU, T_A10_HOLD)),
                                 cyc_max(cyc_max(T_VPP_HOLD, T_A9_HOLD),
                                 cyc_max(T_PULSE, T_VERIFY)));
  localparam int unsigned TW = $clog2(LMAX + 1);

  mm_state_e st, nxt;
  logic tmr_exp, tmr_load;
  logic [TW-1:0] tmr_val;
  logic pc_exhausted, addr_last;
  logic [AW-1:0] addr;
  logic failed_q, done_q;
  logic [AW-1:0] fail_addr_q;

  // Named internal events
  logic start_acc, pulse_end, vfy_done, vfy_hit, vfy_miss;
  logic byte_adv, cmp_done, cmp_miss, cmp_adv, run_abort;

  assign start_acc = (st == ST_IDLE) && start;
  assign pulse_end = (st == ST_PULSE) && tmr_exp;
  assign vfy_done  = (st == ST_VERIFY) && tmr_exp;
  assign vfy_hit   = vfy_done && (ep_dq_in == img_data);
  assign vfy_miss  = vfy_done && (ep_dq_in != img_data);
  assign byte_adv  = vfy_hit && !addr_last;
  assign run_abort = vfy_miss && pc_exhausted;
  assign cmp_done  = (st == ST_CMP) && tmr_exp;
  assign cmp_miss  = cmp_done && (ep_dq_in != img_data);
  assign cmp_adv   = cmp_done && !cmp_miss && !addr_last;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:    if (start)   nxt = ST_A9;
      ST_A9:      if (tmr_exp) nxt = ST_VPP;
      ST_VPP:     if (tmr_exp) nxt = ST_MSET_LO;
      ST_MSET_LO: if (tmr_exp) nxt = ST_MSET_HI;
      ST_MSET_HI: if (tmr_exp) nxt = ST_PRE;
      ST_PRE:     if (tmr_exp) nxt = ST_PULSE;
      ST_PULSE:   if (tmr_exp) nxt = ST_PHOLD;
      ST_PHOLD:   if (tmr_exp) nxt = ST_VERIFY;
      ST_VERIFY:  if (tmr_exp) begin
                    if (vfy_hit) nxt = addr_last ? ST_TD_PRE : ST_PRE;
                    else         nxt = pc_exhausted ? ST_TD_PRE : ST_PRE;
                  end
      ST_TD_PRE:  if (tmr_exp) nxt = ST_MRST_LO;
      ST_MRST_LO: if (tmr_exp) nxt = ST_MRST_HI;
      ST_MRST_HI: if (tmr_exp) nxt = ST_VPP_OFF;
      ST_VPP_OFF: if (tmr_exp) nxt = failed_q ? ST_END : ST_CMP;
      ST_CMP:     if (tmr_exp) nxt = (cmp_miss || addr_last) ? ST_END : ST_CMP;
      ST_END:     nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  assign tmr_load = (st == ST_IDLE) ? start : tmr_exp;
  assign tmr_val  = TW'(phase_len(nxt, T_A9_VPP, T_VPP_CE, T_A10_SU, T_A10_HOLD,
                                  T_VPP_HOLD, T_A9_HOLD, T_PULSE, T_VERIFY) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failed_q    <= 1'b0;
      done_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      if (start_acc) begin
        failed_q <= 1'b0;
        done_q   <= 1'b0;
      end
      if (run_abort || cmp_miss) begin
        failed_q    <= 1'b1;
        fail_addr_q <= addr;
      end
      if (st == ST_END) done_q <= 1'b1;
    end
  end

  mm_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_exp));

  mm_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk(clk), .rst_n(rst_n), .clr(start_acc || byte_adv), .inc(pulse_end),
    .exhausted(pc_exhausted));

  mm_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .clr(start_acc || ((st == ST_VPP_OFF) && tmr_exp)),
    .inc(byte_adv || cmp_adv), .addr(addr), .last(addr_last));

  // Pin levels per phase
  always_comb begin
    ep_ce_n = 1'b1; ep_oe_n = 1'b1; ep_vpp_en = 1'b0; ep_a9_hv = 1'b0;
    ep_margin_line = 1'b0; ep_dq_oe = 1'b0; ep_vcc_hi = 1'b0;
    unique case (st)
      ST_A9, ST_VPP_OFF: begin ep_a9_hv = 1'b1; ep_vcc_hi = 1'b1; end
      ST_VPP, ST_TD_PRE, ST_MRST_HI: begin
        ep_a9_hv = 1'b1; ep_vcc_hi = 1'b1; ep_vpp_en = 1'b1;
      end
      ST_MSET_LO, ST_MSET_HI: begin
        ep_a9_hv = 1'b1; ep_vcc_hi = 1'b1; ep_vpp_en = 1'b1;
        ep_margin_line = 1'b1; ep_ce_n = (st == ST_MSET_HI);
      end
      ST_PRE, ST_PULSE, ST_PHOLD: begin
        ep_a9_hv = 1'b1; ep_vcc_hi = 1'b1; ep_vpp_en = 1'b1;
        ep_dq_oe = 1'b1; ep_ce_n = (st != ST_PULSE);
      end
      ST_VERIFY: begin
        ep_a9_hv = 1'b1; ep_vcc_hi = 1'b1; ep_ce_n = 1'b0; ep_oe_n = 1'b0;
      end
      ST_MRST_LO: begin
        ep_a9_hv = 1'b1; ep_vcc_hi = 1'b1; ep_vpp_en = 1'b1; ep_ce_n = 1'b0;
      end
      ST_CMP: begin ep_ce_n = 1'b0; ep_oe_n = 1'b0; end
      default: ;
    endcase
  end

  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign fail      = failed_q;
  assign fail_addr = fail_addr_q;
  assign img_addr  = addr;
  assign ep_addr   = addr;
  assign ep_dq_out = img_data;

  AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ep_ce_n && ep_oe_n && !ep_vpp_en && !ep_a9_hv && !ep_dq_oe)); // R1
  AST_VPP_NEEDS_A9: assert property (@(posedge clk) disable iff (!rst_n)
    ep_vpp_en |-> ep_a9_hv); // R2
  AST_SEL_STABLE_AT_CE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ep_ce_n) |-> $stable(ep_margin_line)); // R3
  AST_SEL_DROP_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ep_margin_line) |-> (ep_ce_n && $past(ep_ce_n))); // R3
  AST_PULSE_UNDER_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_ce_n && ep_dq_oe) |-> (ep_vpp_en && ep_oe_n)); // R4
  AST_A9_AFTER_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ep_a9_hv) |-> (!ep_vpp_en && $past(!ep_vpp_en))); // R7
  AST_READBACK_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_oe_n && !ep_a9_hv) |-> (!ep_vpp_en && !ep_vcc_hi)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_VPP_OFF_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ep_vpp_en) |-> $past(ep_ce_n)); // R10
endmodule

// File: tb/test_margin_prog_seq.sv
module test_margin_prog_seq;
  localparam int AW = 6, DW = 8, N = 1 << AW;
  localparam int T_A9_VPP = 3, T_VPP_CE = 3, T_A10_SU = 2, T_A10_HOLD = 2;
  localparam int T_VPP_HOLD = 3, T_A9_HOLD = 3, T_PULSE = 6, T_VERIFY = 2;
  localparam int MAX_PULSES = 25;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, fail, ep_dq_oe, ep_ce_n, ep_oe_n, ep_vpp_en, ep_a9_hv;
  logic ep_margin_line, ep_vcc_hi;
  logic [AW-1:0] fail_addr, img_addr, ep_addr;
  logic [DW-1:0] img_data, ep_dq_out, ep_dq_in;

  logic [7:0] image [N];
  int need [N];
  logic [7:0] mem [N];
  int pulses [N];
  logic margin;
  int reads, corrupt_at;
  logic clr_model = 0;

  int total = 0, bad = 0, mon_total = 0, mon_bad = 0;

  always #4 clk = ~clk;

  margin_prog_seq #(.AW(AW), .DW(DW), .T_A9_VPP(T_A9_VPP), .T_VPP_CE(T_VPP_CE),
    .T_A10_SU(T_A10_SU), .T_A10_HOLD(T_A10_HOLD), .T_VPP_HOLD(T_VPP_HOLD),
    .T_A9_HOLD(T_A9_HOLD), .T_PULSE(T_PULSE), .T_VERIFY(T_VERIFY),
    .MAX_PULSES(MAX_PULSES)) i_margin_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .img_addr(img_addr), .img_data(img_data),
    .ep_addr(ep_addr), .ep_dq_out(ep_dq_out), .ep_dq_oe(ep_dq_oe),
    .ep_dq_in(ep_dq_in), .ep_ce_n(ep_ce_n), .ep_oe_n(ep_oe_n),
    .ep_vpp_en(ep_vpp_en), .ep_a9_hv(ep_a9_hv), .ep_margin_line(ep_margin_line),
    .ep_vcc_hi(ep_vcc_hi));

  assign img_data = image[img_addr];
  // Array only drives valid data in a read: enables low, no programming voltage.
  assign ep_dq_in = (!ep_ce_n && !ep_oe_n && !ep_vpp_en) ? mem[ep_addr] : ~mem[ep_addr];

  task automatic mon_chk(bit ok, string req, string what, longint act, longint exp);
    mon_total++;
    if (!ok) begin
      mon_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_pulses(logic [7:0] img, int nd);
    if (img == 8'hFF || nd < 1) return 1;
    return nd;
  endfunction

  // Array model and pin-timing monitor, sampled away from the active edge
  longint cyc = 0, t_a9_rise = -1000, t_vpp_rise = -1000, t_vpp_fall = -1000;
  longint t_ce_fall = -1000, t_ce_rise = -1000, t_sel_chg = -1000, t_mrise = -1000;
  logic p_ce = 1, p_vpp = 0, p_a9 = 0, p_oe = 0, p_sel = 0, after_a9 = 0;

  always @(negedge clk) begin
    cyc++;
    if (clr_model) begin
      for (int i = 0; i < N; i++) begin mem[i] = 8'hFF; pulses[i] = 0; end
      margin = 0; reads = 0; after_a9 = 0;
    end else if (rst_n) begin
      if (ep_a9_hv && !p_a9) begin t_a9_rise = cyc; after_a9 = 0; end
      if (ep_vpp_en && !p_vpp) begin
        mon_chk(cyc - t_a9_rise >= T_A9_VPP, "R2", "a9 to vpp cycles", cyc - t_a9_rise, T_A9_VPP);
        t_vpp_rise = cyc;
      end
      if (!ep_vpp_en && p_vpp) begin
        mon_chk(cyc - t_ce_rise >= T_VPP_HOLD, "R10", "vpp hold after ce", cyc - t_ce_rise, T_VPP_HOLD);
        t_vpp_fall = cyc;
      end
      if (!ep_ce_n && p_ce) begin
        if (ep_vpp_en)
          mon_chk(cyc - t_vpp_rise >= T_VPP_CE, "R2", "vpp to ce low", cyc - t_vpp_rise, T_VPP_CE);
        t_ce_fall = cyc;
      end
      if (ep_ce_n && !p_ce) begin
        if (p_oe && p_vpp) begin
          mon_chk(cyc - t_ce_fall == T_PULSE, "R4", "pulse width", cyc - t_ce_fall, T_PULSE);
          mon_chk(ep_dq_out == image[ep_addr], "R4", "pulse data", ep_dq_out, image[ep_addr]);
          mon_chk(margin == 1'b1, "R3", "margin set at pulse", margin, 1);
          pulses[ep_addr]++;
          if (pulses[ep_addr] >= need[ep_addr]) mem[ep_addr] = mem[ep_addr] & ep_dq_out;
        end else if (p_vpp && ep_a9_hv) begin
          mon_chk(cyc - t_sel_chg >= T_A10_SU, "R3", "select setup", cyc - t_sel_chg, T_A10_SU);
          margin = ep_margin_line;
          t_mrise = cyc;
        end
        t_ce_rise = cyc;
      end
      if (ep_margin_line != p_sel) begin
        mon_chk(cyc - t_mrise >= T_A10_HOLD, "R3", "select hold", cyc - t_mrise, T_A10_HOLD);
        t_sel_chg = cyc;
      end
      if (!ep_a9_hv && p_a9) begin
        mon_chk(cyc - t_vpp_fall >= T_A9_HOLD, "R7", "a9 hold after vpp", cyc - t_vpp_fall, T_A9_HOLD);
        mon_chk(margin == 1'b0, "R7", "margin cleared", margin, 0);
        after_a9 = 1;
        if (corrupt_at >= 0) mem[corrupt_at] = image[corrupt_at] ^ 8'h01;
      end
      if (after_a9 && !ep_ce_n && !ep_oe_n) begin
        mon_chk(!ep_vpp_en && !ep_a9_hv && !ep_vcc_hi, "R8", "read-back voltages",
                {ep_vpp_en, ep_a9_hv, ep_vcc_hi}, 0);
        reads++;
      end
    end
    p_ce = ep_ce_n; p_vpp = ep_vpp_en; p_a9 = ep_a9_hv; p_oe = ep_dq_oe; p_sel = ep_margin_line;
  end

  task automatic reset_model();
    @(posedge clk); clr_model = 1;
    @(posedge clk); clr_model = 0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    ok = done;
    if (!ok) begin bad++; total++; $display("FAIL R9 watchdog: actual=0 expected=1"); end
  endtask

  task automatic run_case(int fail_at, int corr, bit mid_start);
    bit ok;
    corrupt_at = corr;
    reset_model();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    chk(done == 1'b0, "R9", "done cleared by start", done, 0);
    if (mid_start) begin
      repeat (150) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    wait_done(ok);
    if (!ok) return;
    @(negedge clk);
    chk(busy == 1'b0, "R9", "idle at end", busy, 0);
    chk(ep_ce_n && !ep_vpp_en && !ep_a9_hv && !ep_dq_oe, "R1", "pins quiet at end", 0, 0);
    chk(margin == 1'b0, "R7", "margin off after run", margin, 0);
    for (int i = 0; i < N; i++) begin
      int e;
      if (fail_at < 0 || i < fail_at) e = exp_pulses(image[i], need[i]);
      else if (i == fail_at) e = MAX_PULSES;
      else e = 0;
      chk(pulses[i] == e, (fail_at >= 0 && i >= fail_at) ? "R6" : "R5", "pulses per byte", pulses[i], e);
    end
    if (fail_at >= 0) begin
      chk(fail == 1'b1, "R6", "fail flag", fail, 1);
      chk(fail_addr == AW'(fail_at), "R6", "fail address", fail_addr, fail_at);
      chk(reads == 0, "R6", "no read-back after abort", reads, 0);
    end else if (corr >= 0) begin
      chk(fail == 1'b1, "R8", "read-back fail flag", fail, 1);
      chk(fail_addr == AW'(corr), "R8", "read-back fail address", fail_addr, corr);
      chk(reads == (corr + 1) * T_VERIFY, "R8", "read-back stops", reads, (corr + 1) * T_VERIFY);
    end else begin
      chk(fail == 1'b0, "R5", "no fail", fail, 0);
      chk(reads == N * T_VERIFY, "R8", "read-back cycles", reads, N * T_VERIFY);
      for (int i = 0; i < N; i++)
        chk(mem[i] == image[i], "R5", "programmed byte", mem[i], image[i]);
    end
    repeat (10) @(negedge clk);
    chk(done == 1'b1, "R9", "done sticky", done, 1);
  endtask

  initial begin
    void'($urandom(32'd915));
    for (int i = 0; i < N; i++) begin
      image[i] = 8'($urandom());
      need[i]  = 1 + int'($urandom() % 4);
    end
    image[3] = 8'hFF; need[3] = 3;
    image[4] = 8'h00; need[4] = 2;
    corrupt_at = -1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !fail && ep_ce_n && ep_oe_n && !ep_vpp_en && !ep_a9_hv
        && !ep_dq_oe && !ep_vcc_hi, "R1", "pins during reset", 0, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && ep_ce_n && !ep_vpp_en && !ep_a9_hv, "R1", "idle after reset", busy, 0);

    run_case(-1, -1, 1'b1);                       // random image, ignored start
    need[7] = MAX_PULSES;                         // limit exactly reached, passes
    image[20] = 8'h3C; need[20] = MAX_PULSES + 1; // never verifies
    run_case(20, -1, 1'b0);
    need[20] = 2;
    run_case(-1, 33, 1'b0);                       // byte changed before read-back

    total += mon_total; bad += mon_bad;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule